// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software drives it through one control/status word. That word holds the channel select, the operating mode, the interrupt enable, a start/busy bit, a completion flag and a trigger-source select. A conversion is started by a software write of the start bit or by a rising edge on the trigger input that the trigger-source field picks. Those inputs are two timer triggers and one external trigger pin. Each conversion spends one cycle in sample, driven out on `sample`. It then decides one result bit per cycle, from the most significant bit down. For each bit it drives a trial code on `dac_code` and reads the external comparator on `cmp_hi`.

When the last bit is decided, the result is stored in the data register that belongs to the converted channel. In that same cycle the start/busy bit drops and the completion flag is set. The interrupt line is the completion flag ANDed with the interrupt enable. Only single mode converts. The multi, scan and unused mode codes are accepted into the register, but a start request is ignored while one of them is selected.

All pins are plain control and status signals; the block has no streaming interface. Because the start bit is also the abort control, any write during a conversion must carry a 1 in the start bit, or the conversion is abandoned.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0 and `irq` is 0. Every data register reads 0.
- R2: A software write with start bit (bit 6) = 1, while the block is idle and mode (bits 4:3) = 00, sets the busy bit at the write's clock edge. The busy bit then reads 1 for exactly 11 cycles (1 sample cycle + 10 bit cycles) and clears by itself.
- R3: The conversion tests the bits from bit 9 down to bit 0. A trial bit is kept when `cmp_hi` = 1, meaning the input is at or above the trial code. The first bit cycle therefore drives `dac_code` = 512, and a comparator that reports input >= code makes the result equal to that input code.
- R4: The result is written only to the data register selected by the channel field (bits 2:0) that was active during the conversion. All other data registers keep their values.
- R5: The completion flag (bit 7) is set in the same cycle that the busy bit clears. `irq` equals flag AND interrupt enable (bit 5).
- R6: A write while busy does not change the channel, mode or trigger-select fields. A write from idle that sets the start bit applies its channel and mode to the conversion it starts.
- R7: A write with start bit = 0 while busy abandons the conversion at that edge. No data register is written and the flag is unchanged. This holds even if the write lands in the last bit cycle.
- R8: With trigger select (bits 9:8) = 01, 10 or 11, a rising edge on `trig_tmr_a`, `trig_tmr_b` or `trig_ext` respectively starts a conversion at the next clock edge. Edges on the unselected inputs have no effect. Select 00 means software-only start.
- R9: Trigger edges that arrive while a conversion runs are ignored. Exactly one conversion takes place.
- R10: Writing 0 to the flag clears it only if the control word was read (`csr_rd`) while the flag was 1 since the last flag write. Writing 1 to the flag has no effect. A completion in the same cycle as a clearing write leaves the flag at 1.
- R11: With mode 01, 10 or 11, a start request from software or from a trigger is ignored and the busy bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_rd | input | 1 | Control word read strobe (arms flag clearing) |
| csr_wdata | input | 10 | Write data: [2:0] channel, [4:3] mode, [5] int enable, [6] start, [7] flag, [9:8] trigger select |
| csr_rdata | output | 10 | Current control word, same layout |
| rd_sel | input | 3 | Data register index to read |
| rd_data | output | 10 | Contents of the selected data register |
| trig_tmr_a | input | 1 | Timer trigger A |
| trig_tmr_b | input | 1 | Timer trigger B |
| trig_ext | input | 1 | External trigger pin |
| cmp_hi | input | 1 | Comparator: input at or above `dac_code` |
| sample | output | 1 | High during the sample cycle |
| dac_code | output | 10 | Trial code for the DAC during bit cycles |
| irq | output | 1 | Interrupt request level |

## Verification
Two events can land in the same clock edge: the final bit decision and a software write. The bench sets up a write that clears the flag, with the start bit held at 1, and makes it effective at the completion edge. It then checks that the flag is still 1 and that the busy bit has dropped without a restart. The abort case is covered the same way: a write with start = 0 during a conversion must leave both the flag and the target data register unchanged. A comparator model computed from a known input code gives the expected result of every conversion in a full sweep of all 1024 codes.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_RSVD   = 2'b11
  } sar_mode_e;

  typedef enum logic [1:0] {
    TSRC_SW   = 2'b00,
    TSRC_TMRA = 2'b01,
    TSRC_TMRB = 2'b10,
    TSRC_EXT  = 2'b11
  } sar_tsrc_e;

  typedef enum logic [1:0] {
    SAR_IDLE   = 2'b00,
    SAR_SAMPLE = 2'b01,
    SAR_BITS   = 2'b10
  } sar_state_e;
endpackage

// File: rtl/sar_trig_sel.sv
`timescale 1ns/1ps
module sar_trig_sel
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_a,
  input  logic       tmr_b,
  input  logic       ext,
  input  sar_tsrc_e  tsel,
  output logic       hit
);
  localparam int NSRC = 3;
  logic [NSRC-1:0] src, prev_q, rise;

  assign src  = {ext, tmr_b, tmr_a};
  assign rise = src & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  always_comb begin
    unique case (tsel)
      TSRC_TMRA: hit = rise[0];
      TSRC_TMRB: hit = rise[1];
      TSRC_EXT:  hit = rise[2];
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/sar_approx.sv
`timescale 1ns/1ps
module sar_approx
  import sar_pkg::*;
#(
  parameter int NBITS = 10,
  localparam int IW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             sample,
  output logic [NBITS-1:0] dac_code,
  output logic             done,
  output logic [NBITS-1:0] result
);
  localparam logic [NBITS-1:0] ONE = NBITS'(1);

  sar_state_e       state_q;
  logic [IW-1:0]    idx_q;
  logic [NBITS-1:0] acc_q, trial, kept;

  assign trial    = acc_q | (ONE << idx_q);
  assign kept     = cmp_hi ? trial : acc_q;
  assign dac_code = (state_q == SAR_BITS) ? trial : '0;
  assign sample   = (state_q == SAR_SAMPLE);
  assign busy     = (state_q != SAR_IDLE);
  assign done     = (state_q == SAR_BITS) && (idx_q == '0);
  assign result   = kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SAR_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
    end else if (abort) begin
      state_q <= SAR_IDLE;
    end else begin
      unique case (state_q)
        SAR_IDLE: if (go) state_q <= SAR_SAMPLE;
        SAR_SAMPLE: begin
          state_q <= SAR_BITS;
          idx_q   <= IW'(NBITS-1);
          acc_q   <= '0;
        end
        SAR_BITS: begin
          acc_q <= kept;
          if (idx_q == '0) state_q <= SAR_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default: state_q <= SAR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_result_bank.sv
`timescale 1ns/1ps
module sar_result_bank #(
  parameter int NBITS = 10,
  parameter int NCH   = 8,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   we,
  input  logic [NBITS-1:0] wdata,
  input  logic [CHW-1:0]   rd_sel,
  output logic [NBITS-1:0] rd_data
);
  logic [NCH-1:0][NBITS-1:0] regs_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[i] <= '0;
      else if (we[i]) regs_q[i] <= wdata;
    end
  end

  assign rd_data = regs_q[rd_sel];
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS = 10,
  parameter int NCH   = 8,
  localparam int CHW  = $clog2(NCH),
  localparam int CW   = CHW + 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic             csr_rd,
  input  logic [CW-1:0]    csr_wdata,
  output logic [CW-1:0]    csr_rdata,
  input  logic [CHW-1:0]   rd_sel,
  output logic [NBITS-1:0] rd_data,
  input  logic             trig_tmr_a,
  input  logic             trig_tmr_b,
  input  logic             trig_ext,
  input  logic             cmp_hi,
  output logic             sample,
  output logic [NBITS-1:0] dac_code,
  output logic             irq
);
  localparam int P_MODE  = CHW;
  localparam int P_IEN   = CHW + 2;
  localparam int P_START = CHW + 3;
  localparam int P_FLAG  = CHW + 4;
  localparam int P_TSEL  = CHW + 5;

  logic [CHW-1:0]   chan_q;
  sar_mode_e        mode_q, mode_new;
  sar_tsrc_e        tsel_q;
  logic             ien_q, flag_q, armed_q;
  logic             eng_busy, eng_done, trig_hit;
  logic             cfg_open, sw_go, go, abort, commit, flag_wr0;
  logic [NBITS-1:0] eng_result;
  logic [NCH-1:0]   bank_we;

  assign cfg_open = !eng_busy;
  assign mode_new = (csr_wr && cfg_open) ? sar_mode_e'(csr_wdata[P_MODE +: 2]) : mode_q;
  assign sw_go    = csr_wr && csr_wdata[P_START];
  assign go       = cfg_open && (sw_go || trig_hit) && (mode_new == MODE_SINGLE);
  assign abort    = eng_busy && csr_wr && !csr_wdata[P_START];
  assign commit   = eng_done && !abort;
  assign flag_wr0 = csr_wr && !csr_wdata[P_FLAG];

  for (genvar i = 0; i < NCH; i++) begin : g_we
    assign bank_we[i] = commit && (chan_q == CHW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      mode_q <= MODE_SINGLE;
      tsel_q <= TSRC_SW;
      ien_q  <= 1'b0;
    end else if (csr_wr) begin
      ien_q <= csr_wdata[P_IEN];
      if (cfg_open) begin
        chan_q <= csr_wdata[CHW-1:0];
        mode_q <= sar_mode_e'(csr_wdata[P_MODE +: 2]);
        tsel_q <= sar_tsrc_e'(csr_wdata[P_TSEL +: 2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (commit)                   flag_q <= 1'b1;
      else if (flag_wr0 && armed_q) flag_q <= 1'b0;
      if (flag_wr0)                 armed_q <= 1'b0;
      else if (csr_rd && flag_q)    armed_q <= 1'b1;
    end
  end

  sar_trig_sel u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .tmr_a (trig_tmr_a),
    .tmr_b (trig_tmr_b),
    .ext   (trig_ext),
    .tsel  (tsel_q),
    .hit   (trig_hit)
  );

  sar_approx #(.NBITS(NBITS)) u_approx (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .abort    (abort),
    .cmp_hi   (cmp_hi),
    .busy     (eng_busy),
    .sample   (sample),
    .dac_code (dac_code),
    .done     (eng_done),
    .result   (eng_result)
  );

  sar_result_bank #(.NBITS(NBITS), .NCH(NCH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bank_we),
    .wdata   (eng_result),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  assign csr_rdata = {tsel_q, flag_q, eng_busy, ien_q, mode_q, chan_q};
  assign irq       = flag_q & ien_q;
endmodule

// File: rtl/sar_seq_checker.sv
`timescale 1ns/1ps
module sar_seq_checker #(
  parameter int NBITS = 10,
  parameter int NCH   = 8,
  localparam int CHW  = $clog2(NCH),
  localparam int KW   = $clog2(NBITS + 2) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           flag,
  input logic [CHW-1:0] chan,
  input logic [1:0]     mode,
  input logic           conv_done,
  input logic [NCH-1:0] bank_we
);
  logic [KW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + 1'b1;
  end

  p_conv_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> busy_cnt == KW'(NBITS));

  p_one_bank_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  p_flag_with_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $fell(busy));

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(chan) && $stable(mode)));

  p_single_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mode == 2'b00);
endmodule

bind sar_seq_ctrl sar_seq_checker #(.NBITS(NBITS), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (eng_busy),
  .flag      (flag_q),
  .chan      (chan_q),
  .mode      (mode_q),
  .conv_done (eng_done),
  .bank_we   (bank_we)
);

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_wr = 1'b0, csr_rd = 1'b0;
  logic [9:0] csr_wdata = '0;
  logic [9:0] csr_rdata;
  logic [2:0] rd_sel = '0;
  logic [9:0] rd_data;
  logic       trig_tmr_a = 1'b0, trig_tmr_b = 1'b0, trig_ext = 1'b0;
  logic       cmp_hi, sample, irq;
  logic [9:0] dac_code;
  logic [9:0] vin = '0;
  logic [9:0] exp_bank [8];
  int         n_chk = 0, n_bad = 0;
  bit         ended = 0;

  always #2 clk = ~clk;
  assign cmp_hi = (vin >= dac_code);

  sar_seq_ctrl i_sar_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rd_sel(rd_sel),
    .rd_data(rd_data), .trig_tmr_a(trig_tmr_a), .trig_tmr_b(trig_tmr_b),
    .trig_ext(trig_ext), .cmp_hi(cmp_hi), .sample(sample),
    .dac_code(dac_code), .irq(irq)
  );

  function automatic logic [9:0] mk(int ch, int md, bit ie, bit st, bit fl, int ts);
    return {2'(ts), fl, st, ie, 2'(md), 3'(ch)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(logic [9:0] d);
    csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    csr_rd = 1'b1;
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  function automatic int busy_b(); return int'(csr_rdata[6]); endfunction
  function automatic int flag_b(); return int'(csr_rdata[7]); endfunction

  task automatic bank_val(int ch, output int v);
    rd_sel = 3'(ch);
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic clear_flag(int ch, int ts);
    rd_pulse();
    wr(mk(ch, 0, 1'b1, 1'b0, 1'b0, ts));
  endtask

  // Software conversion; returns at the negedge after busy clears.
  task automatic convert(int ch, int v, bit check_len);
    int got;
    vin = 10'(v);
    wr(mk(ch, 0, 1'b1, 1'b1, 1'b0, 0));
    for (int k = 0; k < 11; k++) begin
      if (check_len) chk(busy_b() == 1, "R2 busy during conversion", busy_b(), 1);
      if (check_len && k == 1) chk(dac_code == 10'd512, "R3 first trial code", int'(dac_code), 512);
      @(negedge clk);
    end
    if (check_len) chk(busy_b() == 0, "R2 busy self-clear", busy_b(), 0);
    exp_bank[ch] = 10'(v);
    bank_val(ch, got);
    chk(got == v, "R3 result code", got, v);
  endtask

  initial begin
    #(4 * 150000);
    if (!ended) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    for (int i = 0; i < 8; i++) exp_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(csr_rdata == '0, "R1 control word", int'(csr_rdata), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    for (int c = 0; c < 8; c++) begin
      bank_val(c, v);
      chk(v == 0, "R1 data register", v, 0);
    end

    // R2 R3 R4 full sweep of input codes across channels
    for (int code = 0; code < 1024; code++) convert(code % 8, (code * 389) % 1024, code < 10);
    for (int c = 0; c < 8; c++) begin
      bank_val(c, v);
      chk(v == int'(exp_bank[c]), "R4 bank contents", v, int'(exp_bank[c]));
    end

    // R5 flag set with busy clear, irq level
    clear_flag(2, 0);
    chk(flag_b() == 0 && irq == 0, "R5 flag cleared", flag_b(), 0);
    vin = 10'd300;
    wr(mk(2, 0, 1'b1, 1'b1, 1'b0, 0));
    repeat (10) @(negedge clk);
    chk(flag_b() == 0 && busy_b() == 1, "R5 flag before end", flag_b(), 0);
    @(negedge clk);
    chk(flag_b() == 1 && busy_b() == 0, "R5 flag at end", flag_b(), 1);
    chk(irq == 1, "R5 irq with enable", int'(irq), 1);
    exp_bank[2] = 10'd300;
    wr(mk(2, 0, 1'b0, 1'b0, 1'b1, 0));
    chk(irq == 0, "R5 irq masked", int'(irq), 0);

    // R10 clear rules
    wr(mk(2, 0, 1'b1, 1'b0, 1'b0, 0));
    chk(flag_b() == 1, "R10 clear without read", flag_b(), 1);
    clear_flag(2, 0);
    chk(flag_b() == 0, "R10 clear after read", flag_b(), 0);
    wr(mk(2, 0, 1'b1, 1'b0, 1'b1, 0));
    chk(flag_b() == 0, "R10 write one ignored", flag_b(), 0);

    // R6 config frozen while busy
    vin = 10'd777;
    wr(mk(4, 0, 1'b1, 1'b1, 1'b0, 0));
    repeat (3) @(negedge clk);
    wr(mk(5, 1, 1'b1, 1'b1, 1'b0, 2));
    chk(csr_rdata[2:0] == 3'd4, "R6 channel frozen", int'(csr_rdata[2:0]), 4);
    chk(csr_rdata[4:3] == 2'd0, "R6 mode frozen", int'(csr_rdata[4:3]), 0);
    repeat (10) @(negedge clk);
    bank_val(4, v);
    chk(v == 777, "R6 result in start channel", v, 777);
    bank_val(5, v);
    chk(v == int'(exp_bank[5]), "R6 other channel intact", v, int'(exp_bank[5]));
    exp_bank[4] = 10'd777;

    // R7 abort
    clear_flag(3, 0);
    vin = 10'd5;
    wr(mk(3, 0, 1'b1, 1'b1, 1'b0, 0));
    repeat (4) @(negedge clk);
    wr(mk(3, 0, 1'b1, 1'b0, 1'b0, 0));
    chk(busy_b() == 0, "R7 abort idles", busy_b(), 0);
    repeat (14) @(negedge clk);
    bank_val(3, v);
    chk(v == int'(exp_bank[3]), "R7 no result written", v, int'(exp_bank[3]));
    chk(flag_b() == 0, "R7 flag unchanged", flag_b(), 0);
    // R7 abort in last bit cycle
    wr(mk(3, 0, 1'b1, 1'b1, 1'b0, 0));
    repeat (10) @(negedge clk);
    wr(mk(3, 0, 1'b1, 1'b0, 1'b0, 0));
    bank_val(3, v);
    chk(v == int'(exp_bank[3]) && flag_b() == 0, "R7 late abort", v, int'(exp_bank[3]));

    // R8 trigger selection (timer A selected)
    wr(mk(6, 0, 1'b1, 1'b0, 1'b0, 1));
    vin = 10'd100;
    trig_tmr_b = 1; @(negedge clk); trig_tmr_b = 0;
    chk(busy_b() == 0, "R8 timer B unselected", busy_b(), 0);
    trig_ext = 1; @(negedge clk); trig_ext = 0;
    chk(busy_b() == 0, "R8 external unselected", busy_b(), 0);
    trig_tmr_a = 1; @(negedge clk); trig_tmr_a = 0;
    chk(busy_b() == 1, "R8 timer A starts", busy_b(), 1);
    // R9 trigger during conversion ignored
    repeat (4) @(negedge clk);
    trig_tmr_a = 1; @(negedge clk); trig_tmr_a = 0;
    repeat (6) @(negedge clk);
    chk(busy_b() == 0, "R9 conversion ended", busy_b(), 0);
    repeat (3) @(negedge clk);
    chk(busy_b() == 0, "R9 no second conversion", busy_b(), 0);
    bank_val(6, v);
    chk(v == 100, "R8 trigger result", v, 100);
    exp_bank[6] = 10'd100;
    // R8 external trigger selected
    wr(mk(7, 0, 1'b1, 1'b0, 1'b0, 3));
    vin = 10'd1000;
    trig_ext = 1; @(negedge clk); trig_ext = 0;
    chk(busy_b() == 1, "R8 external starts", busy_b(), 1);
    repeat (11) @(negedge clk);
    bank_val(7, v);
    chk(v == 1000, "R8 external result", v, 1000);

    // R11 reserved modes
    for (int m = 1; m < 4; m++) begin
      wr(mk(1, m, 1'b1, 1'b1, 1'b1, 0));
      chk(busy_b() == 0, "R11 software start ignored", busy_b(), 0);
    end
    wr(mk(1, 2, 1'b1, 1'b0, 1'b1, 1));
    trig_tmr_a = 1; @(negedge clk); trig_tmr_a = 0;
    chk(busy_b() == 0, "R11 trigger start ignored", busy_b(), 0);

    // R10 completion beats clear in the same cycle
    rd_pulse();
    vin = 10'd42;
    wr(mk(0, 0, 1'b1, 1'b1, 1'b1, 0));
    repeat (10) @(negedge clk);
    wr(mk(0, 0, 1'b1, 1'b1, 1'b0, 0));
    chk(flag_b() == 1, "R10 completion wins", flag_b(), 1);
    chk(busy_b() == 0, "R10 no restart", busy_b(), 0);
    bank_val(0, v);
    chk(v == 42, "R10 result stored", v, 42);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule